// File: doc/BRIEF.md
# PCI Power Management Register Pair

This block holds the two 16-bit configuration-space registers a PCI function uses for power management: a control/status word at byte offset 48h and an always-zero extension word at 4Ah. Software reads and writes them through a plain configuration port made of a write strobe, a byte address, two byte enables, write data and read data. Reads are combinational.

The function signals wake-up through a one-cycle `wakeEvent` input. The block records each wake in a sticky status flag. It drives the active-low `pmeN` line low only while that flag is set and software has enabled wake signalling. Software clears the flag by writing a 1 to it. The two-bit device power state is exported on `powerState`.

When software moves the state from D3 to D0, the block raises a one-cycle `funcSoftRst` pulse for the rest of the function. That pulse, and the `softRst` input that carries it back, leave this register untouched. Only `coldRstN` restores the defaults.

Top module: `pm_regpair`

## Requirements
- R1: While and after `coldRstN` is low, the word at 48h and the word at 4Ah both read 0000h, `pmeN` is 1, `powerState` is 00 and `funcSoftRst` is 0.
- R2: A `wakeEvent` sampled at a clock edge sets bit 15 of the word at 48h from that edge on, whatever the value of bit 8.
- R3: A write to 48h with byte enable 1 set and data bit 15 = 1 clears bit 15 and releases `pmeN` to 1. The same write with data bit 15 = 0 leaves bit 15 unchanged.
- R4: `pmeN` is 0 exactly when bit 15 = 1 and bit 8 = 1. Bit 8 is read/write through byte 1.
- R5: Bits 1:0 of 48h are read/write and encode the power state as 00 = D0, 01 = D1, 10 = D2, 11 = D3. The same value appears on `powerState` from the write edge on.
- R6: Bits 14:9 and 7:2 of 48h always read 0, whatever value is written to them.
- R7: An active `softRst` input changes no field of the 48h word.
- R8: The word at 4Ah reads 0000h; writes to it change neither 4Ah nor 48h.
- R9: If a wake event and a write-1-to-clear of bit 15 fall on the same edge, bit 15 remains 1.
- R10: Byte enable 1 alone governs bits 15 and 8, and byte enable 0 alone governs bits 1:0. A write with an enable clear leaves that byte's fields unchanged.
- R11: A write that changes bits 1:0 from 11 to 00 makes `funcSoftRst` 1 for exactly the one cycle after that edge. No other write produces the pulse.
- R12: Only the aligned byte address 48h reaches the control/status word. Any address other than 48h reads 0000h, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Fundamental reset, asynchronous, active low |
| softRst | input | 1 | Internal reset from D3-to-D0 transition; does not affect this register |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgByteEn | input | 2 | Byte enables for the 16-bit word |
| cfgWrData | input | 16 | Write data |
| cfgRdData | output | 16 | Combinational read data for `cfgAddr` |
| wakeEvent | input | 1 | Wake request from the function |
| pmeN | output | 1 | Active-low wake signal |
| powerState | output | 2 | Current device power state |
| funcSoftRst | output | 1 | One-cycle reset pulse on a D3-to-D0 write |

## Verification
Every register updates on the edge that samples the write or the wake event. `cfgRdData`, `pmeN` and `powerState` therefore carry the new value from that edge until the next one. `funcSoftRst` is high for the single cycle that follows the write edge. The bench drives stimulus just after a falling edge and lets one rising edge pass. It then parks the port on an idle read of 48h at the next falling edge and compares every output there against its model, so each result is sampled inside the cycle it is due.

// File: rtl/pm_regpair_pkg.sv
package pm_regpair_pkg;
  localparam int REG_W     = 16;
  localparam int STS_BIT   = 15;
  localparam int EN_BIT    = 8;
  localparam int STATE_W   = 2;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = REG_W / BYTE_W;
  localparam logic [STATE_W-1:0] ST_D0 = 2'b00;
  localparam logic [STATE_W-1:0] ST_D3 = 2'b11;

  typedef struct packed {
    logic               stsClr;
    logic               enLoad;
    logic               enVal;
    logic               stateLoad;
    logic [STATE_W-1:0] stateVal;
    logic               softFire;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_regpair_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h48
) (
  input  logic                 clk,
  input  logic                 coldRstN,
  input  logic                 cfgWr,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [NUM_BYTES-1:0] cfgByteEn,
  input  logic [REG_W-1:0]     cfgWrData,
  input  logic [STATE_W-1:0]   curState,
  output pmStrobe_t            strb
);
  logic csrHit;
  logic hiWr;
  logic loWr;
  logic unusedData;

  assign csrHit = cfgWr && (cfgAddr == CSR_ADDR);
  assign hiWr   = csrHit && cfgByteEn[1];
  assign loWr   = csrHit && cfgByteEn[0];
  assign unusedData = ^cfgWrData;

  always_comb begin
    strb           = '0;
    strb.stsClr    = hiWr && cfgWrData[STS_BIT];
    strb.enLoad    = hiWr;
    strb.enVal     = cfgWrData[EN_BIT];
    strb.stateLoad = loWr;
    strb.stateVal  = cfgWrData[STATE_W-1:0];
    strb.softFire  = loWr && (curState == ST_D3) && (cfgWrData[STATE_W-1:0] == ST_D0);
  end

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!coldRstN)
    (strb.stsClr || strb.enLoad || strb.stateLoad) |-> cfgWr); // R12
  AST_FIRE_FROM_D3: assert property (@(posedge clk) disable iff (!coldRstN)
    strb.softFire |-> (curState == ST_D3) && strb.stateLoad); // R11
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_regpair_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h48,
  parameter logic [ADDR_W-1:0] EXT_ADDR = 8'h4A
) (
  input  logic               clk,
  input  logic               coldRstN,
  input  logic               softRst,
  input  logic               wakeEvent,
  input  pmStrobe_t          strb,
  input  logic [ADDR_W-1:0]  cfgAddr,
  output logic [REG_W-1:0]   cfgRdData,
  output logic               pmeN,
  output logic [STATE_W-1:0] powerState,
  output logic               funcSoftRst
);
  logic               pmeSts;
  logic               pmeEn;
  logic [STATE_W-1:0] stateQ;
  logic               fireQ;
  logic [REG_W-1:0]   csrWord;
  logic [REG_W-1:0]   extWord;

  // Only the fundamental reset clears these; softRst is deliberately absent.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      pmeSts <= 1'b0;
      pmeEn  <= 1'b0;
      stateQ <= ST_D0;
      fireQ  <= 1'b0;
    end else begin
      pmeSts <= wakeEvent || (pmeSts && !strb.stsClr);
      if (strb.enLoad)    pmeEn  <= strb.enVal;
      if (strb.stateLoad) stateQ <= strb.stateVal;
      fireQ <= strb.softFire;
    end
  end

  always_comb begin
    csrWord          = '0;
    csrWord[STS_BIT] = pmeSts;
    csrWord[EN_BIT]  = pmeEn;
    csrWord[STATE_W-1:0] = stateQ;
  end

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_extByte
      assign extWord[b*BYTE_W +: BYTE_W] = '0;
    end
  endgenerate

  always_comb begin
    if (cfgAddr == CSR_ADDR)      cfgRdData = csrWord;
    else if (cfgAddr == EXT_ADDR) cfgRdData = extWord;
    else                          cfgRdData = '0;
  end

  assign pmeN        = !(pmeSts && pmeEn);
  assign powerState  = stateQ;
  assign funcSoftRst = fireQ;

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!coldRstN)
    wakeEvent |=> pmeSts); // R2
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!coldRstN)
    pmeSts && !strb.stsClr |=> pmeSts); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!coldRstN)
    strb.stsClr && !wakeEvent |=> pmeN); // R3
  AST_PME_GATED: assert property (@(posedge clk) disable iff (!coldRstN)
    $fell(pmeN) |-> pmeEn && pmeSts); // R4
  AST_SOFT_HOLDS_STATE: assert property (@(posedge clk) disable iff (!coldRstN)
    softRst && !strb.stateLoad |=> $stable(powerState)); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!coldRstN)
    funcSoftRst |=> !funcSoftRst); // R11
  AST_EXT_ZERO: assert property (@(posedge clk) disable iff (!coldRstN)
    (cfgAddr == EXT_ADDR) |-> (cfgRdData == '0)); // R8
endmodule

// File: rtl/pm_regpair.sv
module pm_regpair
  import pm_regpair_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h48,
  parameter logic [ADDR_W-1:0] EXT_ADDR = 8'h4A
) (
  input  logic        clk,
  input  logic        coldRstN,
  input  logic        softRst,
  input  logic        cfgWr,
  input  logic [7:0]  cfgAddr,
  input  logic [1:0]  cfgByteEn,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData,
  input  logic        wakeEvent,
  output logic        pmeN,
  output logic [1:0]  powerState,
  output logic        funcSoftRst
);
  pmStrobe_t strb;

  pm_ctrl #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) i_ctrl (
    .clk(clk), .coldRstN(coldRstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .curState(powerState),
    .strb(strb)
  );

  pm_datapath #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .EXT_ADDR(EXT_ADDR)) i_dp (
    .clk(clk), .coldRstN(coldRstN), .softRst(softRst), .wakeEvent(wakeEvent),
    .strb(strb), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData), .pmeN(pmeN),
    .powerState(powerState), .funcSoftRst(funcSoftRst)
  );
endmodule

// File: tb/test_pm_regpair.sv
module test_pm_regpair;
  logic        clk = 1'b0;
  logic        coldRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cfgWr = 1'b0;
  logic [7:0]  cfgAddr = 8'h48;
  logic [1:0]  cfgByteEn = 2'b00;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic        wakeEvent = 1'b0;
  logic        pmeN;
  logic [1:0]  powerState;
  logic        funcSoftRst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic       mSts = 1'b0;
  logic       mEn = 1'b0;
  logic [1:0] mState = 2'b00;
  logic       mPulse = 1'b0;

  always #5 clk = ~clk;

  pm_regpair i_pm_regpair (
    .clk(clk), .coldRstN(coldRstN), .softRst(softRst), .cfgWr(cfgWr),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .wakeEvent(wakeEvent), .pmeN(pmeN),
    .powerState(powerState), .funcSoftRst(funcSoftRst)
  );

  function automatic logic [15:0] expCsr();
    return {mSts, 6'b0, mEn, 6'b0, mState};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    cfgAddr = 8'h48;
    #1;
    check({tag, " R4 csr"}, cfgRdData, expCsr());
    check({tag, " R4 pmeN"}, {15'b0, pmeN}, {15'b0, !(mSts && mEn)});
    check({tag, " R5 state"}, {14'b0, powerState}, {14'b0, mState});
    check({tag, " R11 pulse"}, {15'b0, funcSoftRst}, {15'b0, mPulse});
  endtask

  // Drive one cycle of stimulus, update the model at the edge, then check.
  task automatic step(string tag, bit wr, logic [7:0] a, logic [1:0] be,
                      logic [15:0] d, bit wk, bit sr);
    bit hit;
    cfgWr = wr; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    wakeEvent = wk; softRst = sr;
    @(posedge clk);
    hit = wr && (a == 8'h48);
    mPulse = hit && be[0] && (mState == 2'b11) && (d[1:0] == 2'b00);
    mSts = wk || (mSts && !(hit && be[1] && d[15]));
    if (hit && be[1]) mEn = d[8];
    if (hit && be[0]) mState = d[1:0];
    @(negedge clk);
    cfgWr = 1'b0; wakeEvent = 1'b0; softRst = 1'b0;
    checkAll(tag);
  endtask

  task automatic readAt(string tag, logic [7:0] a, logic [15:0] exp);
    cfgAddr = a;
    #1;
    check(tag, cfgRdData, exp);
    cfgAddr = 8'h48;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 csr", cfgRdData, 16'h0000);
    readAt("R1 ext", 8'h4A, 16'h0000);
    check("R1 pmeN", {15'b0, pmeN}, 16'h0001);
    check("R1 pulse", {15'b0, funcSoftRst}, 16'h0000);
    coldRstN = 1'b1;
    @(negedge clk);

    // R2 wake with enable off: status sets, pmeN stays high
    step("R2 wake-disabled", 0, 8'h48, 2'b00, 16'h0, 1, 0);
    check("R2 status", {15'b0, cfgRdData[15]}, 16'h0001);
    // R4 enabling drives pmeN low
    step("R4 enable", 1, 8'h48, 2'b10, 16'h0100, 0, 0);
    check("R4 pmeN low", {15'b0, pmeN}, 16'h0000);
    // R3 write 0 to bit 15: no effect
    step("R3 write0", 1, 8'h48, 2'b10, 16'h0100, 0, 0);
    // R3 write 1 clears and releases
    step("R3 write1", 1, 8'h48, 2'b10, 16'h8100, 0, 0);
    check("R3 released", {15'b0, pmeN}, 16'h0001);
    // R9 wake wins over simultaneous clear
    step("R9 prep", 0, 8'h48, 2'b00, 16'h0, 1, 0);
    step("R9 collide", 1, 8'h48, 2'b10, 16'h8100, 1, 0);
    check("R9 still set", {15'b0, cfgRdData[15]}, 16'h0001);
    // R6 reserved bits ignore ones
    step("R6 reserved", 1, 8'h48, 2'b11, 16'h7EFC, 0, 0);
    check("R6 reserved zero", cfgRdData & 16'h7EFC, 16'h0000);
    // R10 byte enable 0 only: enable and status untouched
    step("R10 lo only", 1, 8'h48, 2'b01, 16'h8002, 0, 0);
    step("R10 hi only", 1, 8'h48, 2'b10, 16'h0003, 0, 0);
    // R5 each encoding
    for (int s = 0; s < 4; s++) step("R5 state", 1, 8'h48, 2'b01, 16'(s), 0, 0);
    // R11 D3 -> D0 pulse, then one-cycle
    step("R11 fire", 1, 8'h48, 2'b01, 16'h0000, 0, 0);
    check("R11 pulse high", {15'b0, funcSoftRst}, 16'h0001);
    step("R11 after", 0, 8'h48, 2'b00, 16'h0, 0, 0);
    step("R11 D2->D0", 1, 8'h48, 2'b01, 16'h0002, 0, 0);
    step("R11 no fire", 1, 8'h48, 2'b01, 16'h0000, 0, 0);
    // R7 softRst leaves fields alone
    step("R7 set", 1, 8'h48, 2'b11, 16'h0103, 1, 0);
    step("R7 soft", 0, 8'h48, 2'b00, 16'h0, 0, 1);
    check("R7 intact", cfgRdData, 16'h8103);
    // R8 ext writes ignored
    step("R8 ext write", 1, 8'h4A, 2'b11, 16'hFFFF, 0, 0);
    readAt("R8 ext read", 8'h4A, 16'h0000);
    // R12 other address
    step("R12 odd addr", 1, 8'h49, 2'b11, 16'h8000, 0, 0);
    readAt("R12 other read", 8'h40, 16'h0000);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      case ($urandom_range(3))
        0: a = 8'h4A;
        1: a = 8'(($urandom_range(127)) * 2);
        default: a = 8'h48;
      endcase
      step("R2/R3/R9/R10/R12 rand", 1'($urandom_range(1)), a,
           2'($urandom_range(3)), 16'($urandom),
           $urandom_range(7) == 0, $urandom_range(7) == 0);
      readAt("R8 rand ext", 8'h4A, 16'h0000);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule